// File: doc/BRIEF.md
# Slot-Table Flit Injection Regulator

This block sits in the network interface between an end node and the on-chip network. It decides when each of several connections may put a flit on the single link into the network. Time is cut into fixed-size slots. A per-slot table names the connection that owns each slot. A central scheduler programs that table; the routers downstream hold no schedule of their own. A flit is one link word, and the flits of each connection leave in the order the node queued them.

On the node side, each connection has a small queue with a valid/ready handshake. A global slot strobe marks the start of each slot. On that strobe, the block reads the table entry under its slot pointer. If the entry is valid and the owning queue holds a flit, that flit goes out. If not, the slot stays empty, because an unused slot is never lent to another connection. The pointer then steps forward and wraps at the programmed table length.

The table is double-buffered. Configuration writes land in a shadow copy. A commit marks the shadow copy as ready, and the swap happens only when the pointer returns to slot 0. Connections therefore keep running while a new schedule is written, and a partly written schedule is never followed.

Top module: `slot_inject_regulator`

## Requirements
- R1: After a synchronous active-low reset, `net_valid` is 0, every `in_ready` bit is 1, and `slot_idx` is 0. The active and shadow tables hold no valid entries, and both lengths are `MAX_SLOTS`.
- R2: Each connection queue holds `FIFO_DEPTH` (4) flits. `in_ready[c]` is 0 while queue c is full, and a flit offered then is dropped.
- R3: Flits of one connection leave in the order they were accepted.
- R4: On a cycle with `slot_tick` = 1, the block reads the active entry at `slot_idx`. If that entry is valid and its queue is non-empty, the head flit appears on `net_flit` one cycle later, with `net_valid` = 1 and `net_conn` = the entry's connection index, for exactly one cycle.
- R5: `net_valid` is 1 only in the cycle after a `slot_tick`, so at most one flit leaves per slot.
- R6: If the owner of the current slot has an empty queue, no flit leaves in that slot, even when other queues hold flits.
- R7: An invalid table entry produces an empty slot.
- R8: Each `slot_tick` advances `slot_idx` by one, one cycle later. After the last slot (active length − 1) it goes back to 0. A programmed length of 0 or above `MAX_SLOTS` is stored as `MAX_SLOTS`.
- R9: Entry and length writes go to the shadow table only. After `cfg_commit`, the shadow table becomes active on the first `slot_tick` that wraps the pointer to 0, and it governs the slots from the next tick onward. Without a commit, writes never take effect.
- R10: Without `slot_tick`, `slot_idx` holds its value and no flit leaves.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| slot_tick | input | 1 | Global slot strobe, one cycle per slot |
| in_valid | input | N_CONN | Per-connection flit offer |
| in_ready | output | N_CONN | Per-connection queue has room |
| in_flit | input | N_CONN*FLIT_W | Per-connection flit, connection c at bits [c*FLIT_W +: FLIT_W] |
| cfg_we | input | 1 | Write one shadow table entry |
| cfg_addr | input | PTR_W | Slot index of the write |
| cfg_entry_valid | input | 1 | Valid bit of the written entry |
| cfg_entry_conn | input | CONN_W | Connection index of the written entry |
| cfg_len_we | input | 1 | Write the shadow table length |
| cfg_len | input | LEN_W | Shadow table length, 1..MAX_SLOTS |
| cfg_commit | input | 1 | Mark shadow table for swap at next wrap |
| net_valid | output | 1 | Flit present on the network link |
| net_flit | output | FLIT_W | Injected flit |
| net_conn | output | CONN_W | Connection that owns the injected flit |
| slot_idx | output | PTR_W | Current slot pointer |

## Verification
The injected flit and the new `slot_idx` are both due one cycle after the clock edge that samples `slot_tick`. `in_ready` reflects a push one cycle after the accepting edge. A committed table is first read on the tick that follows the wrapping tick. The driver raises `slot_tick` for one cycle and pushes the expected outcome of that slot into a queue; the outcome is a flit with its connection, or an empty slot. The monitor samples one time unit after each rising edge and pops one expectation for each edge that saw a tick. Every other edge must show `net_valid` low. `slot_idx` and `in_ready` are read at the falling edge after the cycle that should have changed them.

// File: rtl/slot_inject_pkg.sv
// Shared types for the slot-table injection regulator.
// Assumes at most 2**CONN_FIELD_W connections per interface.
package slot_inject_pkg;
    localparam int CONN_FIELD_W = 4;

    // One slot of the transmission table.
    typedef struct packed {
        logic                    valid;
        logic [CONN_FIELD_W-1:0] conn;
    } slot_entry_t;

    // Clamp a programmed length into 1..max_slots.
    function automatic int unsigned clamp_len(int unsigned len, int unsigned max_slots);
        return (len == 0 || len > max_slots) ? max_slots : len;
    endfunction
endpackage

// File: rtl/conn_flit_fifo.sv
// Per-connection flit queue with a valid/ready write side.
// The read side pops on `pop`, and the caller only pops when `empty` is low.
// Assumes DEPTH >= 2. A push and a pop may happen in the same cycle.
module conn_flit_fifo #(
    parameter int WIDTH = 32,
    parameter int DEPTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push_valid,
    output logic             push_ready,
    input  logic [WIDTH-1:0] push_data,
    input  logic             pop,
    output logic             empty,
    output logic [WIDTH-1:0] head
);
    localparam int AW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH + 1);

    logic [WIDTH-1:0] mem_q [DEPTH];
    logic [AW-1:0]    wr_q, rd_q;
    logic [CW-1:0]    cnt_q;
    logic             do_push;

    assign push_ready = (cnt_q != CW'(DEPTH));
    assign empty      = (cnt_q == '0);
    assign head       = mem_q[rd_q];
    assign do_push    = push_valid && push_ready;

    // Storage write; the data needs no reset.
    always_ff @(posedge clk) begin
        if (do_push) mem_q[wr_q] <= push_data;
    end

    // Pointer and occupancy update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_q  <= '0;
            rd_q  <= '0;
            cnt_q <= '0;
        end else begin
            if (do_push) wr_q <= (wr_q == AW'(DEPTH - 1)) ? '0 : wr_q + 1'b1;
            if (pop)     rd_q <= (rd_q == AW'(DEPTH - 1)) ? '0 : rd_q + 1'b1;
            if (do_push && !pop)      cnt_q <= cnt_q + 1'b1;
            else if (pop && !do_push) cnt_q <= cnt_q - 1'b1;
        end
    end
endmodule

// File: rtl/slot_table.sv
// Double-buffered transmission table with the slot pointer.
// Writes go to the shadow copy. A commit arms a swap, and the swap runs
// on the advance that wraps the pointer to 0. The pointer steps once per advance.
// Assumes MAX_SLOTS fits in LEN_W bits.
module slot_table
    import slot_inject_pkg::*;
#(
    parameter int MAX_SLOTS = 16,
    parameter int PTR_W     = 4,
    parameter int LEN_W     = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [PTR_W-1:0] cfg_addr,
    input  slot_entry_t      cfg_entry,
    input  logic             cfg_len_we,
    input  logic [LEN_W-1:0] cfg_len,
    input  logic             cfg_commit,
    input  logic             advance,
    output logic [PTR_W-1:0] cur_ptr,
    output slot_entry_t      cur_entry
);
    slot_entry_t      shadow_q [MAX_SLOTS];
    slot_entry_t      active_q [MAX_SLOTS];
    logic [LEN_W-1:0] shadow_len_q, active_len_q;
    logic [PTR_W-1:0] ptr_q;
    logic             pending_q;
    logic             wrap, swap;

    assign wrap      = (LEN_W'(ptr_q) + 1'b1) >= active_len_q;
    assign swap      = advance && wrap && pending_q;
    assign cur_ptr   = ptr_q;
    assign cur_entry = active_q[ptr_q];

    // Shadow entries and length, written by the scheduler.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < MAX_SLOTS; i++) shadow_q[i] <= '0;
            shadow_len_q <= LEN_W'(MAX_SLOTS);
        end else begin
            if (cfg_we) shadow_q[cfg_addr] <= cfg_entry;
            if (cfg_len_we) shadow_len_q <= LEN_W'(clamp_len(int'(cfg_len), MAX_SLOTS));
        end
    end

    // Active copy, replaced only at a wrap with a commit armed.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < MAX_SLOTS; i++) active_q[i] <= '0;
            active_len_q <= LEN_W'(MAX_SLOTS);
        end else if (swap) begin
            for (int i = 0; i < MAX_SLOTS; i++) active_q[i] <= shadow_q[i];
            active_len_q <= shadow_len_q;
        end
    end

    // Commit flag; a commit in the swap cycle arms the next wrap.
    always_ff @(posedge clk) begin
        if (!rst_n)          pending_q <= 1'b0;
        else if (swap)       pending_q <= cfg_commit;
        else if (cfg_commit) pending_q <= 1'b1;
    end

    // Slot pointer, one step per advance, wrapping at the active length.
    always_ff @(posedge clk) begin
        if (!rst_n)       ptr_q <= '0;
        else if (advance) ptr_q <= wrap ? '0 : ptr_q + 1'b1;
    end
endmodule

// File: rtl/slot_inject_regulator.sv
// Network-interface injection regulator driven by a slot table.
// One flit at most per slot, taken from the queue of the slot's owner.
// An unused slot stays empty. Assumes 2 <= N_CONN <= 16 and that
// slot_tick is a one-cycle strobe.
module slot_inject_regulator
    import slot_inject_pkg::*;
#(
    parameter int N_CONN     = 4,
    parameter int FLIT_W     = 32,
    parameter int FIFO_DEPTH = 4,
    parameter int MAX_SLOTS  = 16,
    parameter int CONN_W     = $clog2(N_CONN),
    parameter int PTR_W      = $clog2(MAX_SLOTS),
    parameter int LEN_W      = $clog2(MAX_SLOTS + 1)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     slot_tick,
    input  logic [N_CONN-1:0]        in_valid,
    output logic [N_CONN-1:0]        in_ready,
    input  logic [N_CONN*FLIT_W-1:0] in_flit,
    input  logic                     cfg_we,
    input  logic [PTR_W-1:0]         cfg_addr,
    input  logic                     cfg_entry_valid,
    input  logic [CONN_W-1:0]        cfg_entry_conn,
    input  logic                     cfg_len_we,
    input  logic [LEN_W-1:0]         cfg_len,
    input  logic                     cfg_commit,
    output logic                     net_valid,
    output logic [FLIT_W-1:0]        net_flit,
    output logic [CONN_W-1:0]        net_conn,
    output logic [PTR_W-1:0]         slot_idx
);
    slot_entry_t       wr_entry, cur_entry;
    logic [N_CONN-1:0] q_empty, q_pop;
    logic [FLIT_W-1:0] q_head [N_CONN];
    logic [CONN_W-1:0] sel;
    logic              sel_ok, fire;
    logic [FLIT_W-1:0] sel_head;

    assign wr_entry.valid = cfg_entry_valid;
    assign wr_entry.conn  = CONN_FIELD_W'(cfg_entry_conn);

    slot_table #(
        .MAX_SLOTS(MAX_SLOTS), .PTR_W(PTR_W), .LEN_W(LEN_W)
    ) u_table (
        .clk(clk), .rst_n(rst_n),
        .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_entry(wr_entry),
        .cfg_len_we(cfg_len_we), .cfg_len(cfg_len), .cfg_commit(cfg_commit),
        .advance(slot_tick), .cur_ptr(slot_idx), .cur_entry(cur_entry)
    );

    for (genvar c = 0; c < N_CONN; c++) begin : g_queue
        conn_flit_fifo #(.WIDTH(FLIT_W), .DEPTH(FIFO_DEPTH)) u_fifo (
            .clk(clk), .rst_n(rst_n),
            .push_valid(in_valid[c]), .push_ready(in_ready[c]),
            .push_data(in_flit[c*FLIT_W +: FLIT_W]),
            .pop(q_pop[c]), .empty(q_empty[c]), .head(q_head[c])
        );
    end

    // Owner of the current slot and whether it can send now.
    always_comb begin
        sel      = CONN_W'(cur_entry.conn);
        sel_ok   = (int'(cur_entry.conn) < N_CONN);
        sel_head = '0;
        fire     = 1'b0;
        q_pop    = '0;
        for (int c = 0; c < N_CONN; c++) begin
            if (sel_ok && sel == CONN_W'(c)) begin
                sel_head = q_head[c];
                fire     = slot_tick && cur_entry.valid && !q_empty[c];
                q_pop[c] = fire;
            end
        end
    end

    // Output register toward the network link.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            net_valid <= 1'b0;
            net_flit  <= '0;
            net_conn  <= '0;
        end else begin
            net_valid <= fire;
            if (fire) begin
                net_flit <= sel_head;
                net_conn <= sel;
            end
        end
    end
endmodule

// File: rtl/slot_inject_regulator_checker.sv
// Port-level temporal checks for the slot-table injection regulator.
// Bound to every instance of the top module.
module slot_inject_regulator_checker #(
    parameter int N_CONN = 4,
    parameter int PTR_W  = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              slot_tick,
    input logic              net_valid,
    input logic [N_CONN-1:0] in_ready,
    input logic [PTR_W-1:0]  slot_idx
);
    // R1: the cycle after reset shows the idle state.
    p_reset_state_r1: assert property (@(posedge clk)
        !rst_n |=> (!net_valid && slot_idx == '0 && (&in_ready)));

    // R5: no flit leaves without a slot strobe in the previous cycle.
    p_flit_needs_tick_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !slot_tick |=> !net_valid);

    // R10: the pointer holds between strobes.
    p_slot_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !slot_tick |=> $stable(slot_idx));

    // R8: a strobe steps the pointer by one or wraps it to 0.
    p_slot_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
        slot_tick |=> (slot_idx == $past(slot_idx) + 1'b1) || (slot_idx == '0));
endmodule

bind slot_inject_regulator slot_inject_regulator_checker #(
    .N_CONN(N_CONN), .PTR_W(PTR_W)
) u_checker (
    .clk(clk), .rst_n(rst_n), .slot_tick(slot_tick), .net_valid(net_valid),
    .in_ready(in_ready), .slot_idx(slot_idx)
);

// File: tb/slot_inject_regulator_test.sv
`timescale 1ns/1ps
// Scoreboard bench: tick tasks predict each slot's outcome, a monitor compares.
module slot_inject_regulator_test;
    localparam int N  = 4;
    localparam int W  = 16;
    localparam int MS = 16;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         slot_tick = 1'b0;
    logic [N-1:0] in_valid = '0;
    logic [N-1:0] in_ready;
    logic [N*W-1:0] in_flit = '0;
    logic         cfg_we = 1'b0, cfg_entry_valid = 1'b0, cfg_len_we = 1'b0, cfg_commit = 1'b0;
    logic [3:0]   cfg_addr = '0;
    logic [1:0]   cfg_entry_conn = '0;
    logic [4:0]   cfg_len = '0;
    logic         net_valid;
    logic [W-1:0] net_flit;
    logic [1:0]   net_conn;
    logic [3:0]   slot_idx;

    int checks = 0, errors = 0;
    bit done = 0;

    // Bench model of the table, queues and pointer.
    logic [W-1:0] mq [N][$];
    bit act_v[MS], sh_v[MS];
    int act_c[MS], sh_c[MS];
    int act_len = MS, sh_len = MS, mptr = 0;
    bit pend = 0;
    string tag_override = "";

    // Expectation queues, one entry per slot strobe.
    bit    ev_q[$];
    int    ec_q[$];
    int    ef_q[$];
    string et_q[$];

    slot_inject_regulator #(.N_CONN(N), .FLIT_W(W), .FIFO_DEPTH(4), .MAX_SLOTS(MS)) uut (
        .clk(clk), .rst_n(rst_n), .slot_tick(slot_tick),
        .in_valid(in_valid), .in_ready(in_ready), .in_flit(in_flit),
        .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_entry_valid(cfg_entry_valid),
        .cfg_entry_conn(cfg_entry_conn), .cfg_len_we(cfg_len_we), .cfg_len(cfg_len),
        .cfg_commit(cfg_commit), .net_valid(net_valid), .net_flit(net_flit),
        .net_conn(net_conn), .slot_idx(slot_idx)
    );

    always #5 clk = ~clk;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    // Driver: one slot strobe, with its predicted outcome queued.
    task automatic do_tick();
        int c, nxt;
        string tg;
        @(negedge clk);
        c = act_c[mptr];
        if (act_v[mptr] && mq[c].size() > 0) begin
            ev_q.push_back(1); ec_q.push_back(c); ef_q.push_back(int'(mq[c].pop_front()));
            tg = "R4 R3";
        end else begin
            ev_q.push_back(0); ec_q.push_back(0); ef_q.push_back(0);
            tg = act_v[mptr] ? "R6" : "R7";
        end
        et_q.push_back(tag_override != "" ? tag_override : tg);
        nxt = (mptr + 1 >= act_len) ? 0 : mptr + 1;
        if (nxt == 0 && pend) begin
            for (int i = 0; i < MS; i++) begin act_v[i] = sh_v[i]; act_c[i] = sh_c[i]; end
            act_len = sh_len; pend = 0;
        end
        mptr = nxt;
        slot_tick = 1'b1;
        @(negedge clk);
        slot_tick = 1'b0;
        check(slot_idx == 4'(mptr), "R8", slot_idx, mptr);
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) do_tick();
    endtask

    // Driver: offer one flit to connection c and check the handshake.
    task automatic push_flit(input int c, input logic [W-1:0] f);
        bit room;
        @(negedge clk);
        room = (mq[c].size() < 4);
        check(in_ready[c] == room, "R2", in_ready[c], room);
        in_valid[c] = 1'b1;
        in_flit[c*W +: W] = f;
        if (room) mq[c].push_back(f);
        @(negedge clk);
        in_valid[c] = 1'b0;
    endtask

    task automatic write_entry(input int a, input bit v, input int c);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = 4'(a); cfg_entry_valid = v; cfg_entry_conn = 2'(c);
        sh_v[a] = v; sh_c[a] = c;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic write_len(input int l);
        @(negedge clk);
        cfg_len_we = 1'b1; cfg_len = 5'(l); sh_len = l;
        @(negedge clk);
        cfg_len_we = 1'b0;
    endtask

    task automatic commit();
        @(negedge clk);
        cfg_commit = 1'b1; pend = 1;
        @(negedge clk);
        cfg_commit = 1'b0;
    endtask

    // Monitor: compare each post-strobe cycle with the queued prediction.
    initial begin
        bit t;
        forever begin
            @(posedge clk);
            t = slot_tick;
            #1;
            if (rst_n) begin
                if (t) begin
                    if (ev_q.size() == 0) begin
                        check(0, "R5", 1, 0);
                    end else begin
                        bit ev; int ec, ef; string et;
                        ev = ev_q.pop_front(); ec = ec_q.pop_front();
                        ef = ef_q.pop_front(); et = et_q.pop_front();
                        check(net_valid == ev, et, net_valid, ev);
                        if (ev && net_valid) begin
                            check(int'(net_conn) == ec, et, net_conn, ec);
                            check(int'(net_flit) == ef, et, net_flit, ef);
                        end
                    end
                end else if (net_valid) begin
                    check(0, "R5 R10", net_valid, 0);
                end
            end
        end
    end

    // Watchdog.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual running expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int hold;
        for (int i = 0; i < MS; i++) begin act_v[i] = 0; sh_v[i] = 0; act_c[i] = 0; sh_c[i] = 0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state at the ports.
        check(net_valid == 1'b0, "R1", net_valid, 0);
        check(in_ready == '1, "R1", in_ready, 4'hF);
        check(slot_idx == '0, "R1", slot_idx, 0);

        // R2: fill connection 0, then a fifth offer is refused.
        for (int i = 1; i <= 5; i++) push_flit(0, 16'hA000 + 16'(i));

        // R9: shadow writes without a commit are never used.
        write_len(4);
        write_entry(0, 1, 0);
        write_entry(1, 1, 1);
        write_entry(2, 0, 0);
        write_entry(3, 1, 2);
        tag_override = "R9";
        ticks(MS);
        commit();
        ticks(MS);
        tag_override = "";

        // R4 R6 R7 R8: run the new four-slot table.
        push_flit(1, 16'hB001);
        push_flit(1, 16'hB002);
        ticks(2);
        // R10: no strobe, pointer holds and nothing leaves.
        hold = slot_idx;
        repeat (5) @(negedge clk);
        check(slot_idx == 4'(hold), "R10", slot_idx, hold);
        ticks(6);

        // R9: rewrite while running; the old table runs until the wrap.
        push_flit(2, 16'hC001);
        write_len(3);
        write_entry(0, 1, 3);
        write_entry(1, 1, 3);
        write_entry(2, 1, 0);
        commit();
        push_flit(3, 16'hD001);
        push_flit(3, 16'hD002);
        push_flit(3, 16'hD003);
        tag_override = "R9";
        ticks(4);
        tag_override = "";
        ticks(6);

        // R8: single-slot table; out-of-range length written then corrected.
        write_len(0);
        write_len(1);
        write_entry(0, 1, 1);
        commit();
        ticks(3);
        push_flit(1, 16'hB003);
        push_flit(1, 16'hB004);
        ticks(3);

        repeat (3) @(negedge clk);
        check(ev_q.size() == 0, "R5", ev_q.size(), 0);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule